// File: doc/BRIEF.md
# Serial Video to Two-Pixel Parallel Capture Adapter

This block accepts a one-bit serial pixel stream from an instrument's digital video output, together with its pixel clock and two active-low syncs, and turns it into a form that a processor can capture by polling pins in software. Each pair of consecutive pixels is packed into a two-bit word. A sample clock at one quarter of the pixel rate marks each new word with one of its edges, rising or falling. The two syncs are merged into one sync output.

All state changes on the falling edge of the pixel clock, because the serial data is valid there. The output word, the sample clock and the merged sync all come out of one register stage. They therefore change together, without glitches. The word then holds for the whole two-pixel interval up to the next sample-clock edge, which suits a reader that may look tens of nanoseconds after an edge. Horizontal sync re-phases the divider and the pairing on every line, so the first word of a line is always pixels 0 and 1.

Top module: `vcap_pair_adapter`

## Requirements
- R1: The serial pixel input is sampled only on falling edges of `pix_clk`, and every output changes only just after a falling edge.
- R2: While `hsync_n` is high, `smp_clk` toggles on every second falling edge. Its period is therefore four pixel clocks.
- R3: Each word on `pix_pair` holds two consecutive pixels. The earlier (left) pixel is on bit 1 and the later pixel is on bit 0.
- R4: `pix_pair` changes only on a falling edge where `smp_clk` also changes, or where horizontal sync clears it.
- R5: A word stays unchanged for the two pixel clocks between sample-clock edges.
- R6: `sync_out` equals the XOR of `hsync_n` and `vsync_n` as sampled on the previous falling edge. It is 0 when both syncs idle high and 1 when exactly one of them is low.
- R7: After any falling edge at which `hsync_n` is low, both `smp_clk` and `pix_pair` are 0.
- R8: The first pixel sampled with `hsync_n` high is pixel 0 of the line. The first word of the line is pixels 0 and 1, and `smp_clk` rises with it. This holds whatever phase the previous line ended in.
- R9: While `rst_n` is low, `smp_clk`, `pix_pair` and `sync_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pix_clk | input | 1 | Incoming pixel clock; its falling edge is active |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_pix | input | 1 | Serial pixel data, valid at the falling edge |
| hsync_n | input | 1 | Horizontal sync, active low |
| vsync_n | input | 1 | Vertical sync, active low |
| smp_clk | output | 1 | Divided sample clock; each edge marks a new word |
| pix_pair | output | 2 | Packed pixel pair; bit 1 holds the left pixel |
| sync_out | output | 1 | Registered XOR of the two syncs |

## Verification
Every output is due one falling edge after the input sample that causes it. A word appears on the falling edge that samples its second pixel, and the sample clock toggles on that same edge. The merged sync follows the syncs sampled one falling edge earlier. The bench changes inputs only on rising edges. For each falling edge, the driver pushes the expected output values into a queue, and the monitor compares them 1 ns after that same falling edge. Lines of odd and even length, with vertical sync pulses inside them, check both the re-phasing at the start of a line and the merged sync.

// File: rtl/vcap_pkg.sv
package vcap_pkg;
    // Pixels delivered in parallel per output word
    localparam int unsigned VCAP_PPW_DEFAULT = 2;

    // Output levels forced during blanking and reset
    localparam logic VCAP_SMP_IDLE = 1'b0;
endpackage

// File: rtl/vcap_sync_xor.sv
module vcap_sync_xor (
    input  logic clk_n_edge,
    input  logic rst_n,
    input  logic hs_n,
    input  logic vs_n,
    output logic sync_o
);
    logic sync_d, sync_q;

    always_comb begin
        sync_d = hs_n ^ vs_n;
    end

    always_ff @(negedge clk_n_edge or negedge rst_n) begin
        if (!rst_n) sync_q <= 1'b0;
        else        sync_q <= sync_d;
    end

    assign sync_o = sync_q;
endmodule

// File: rtl/vcap_pair_packer.sv
module vcap_pair_packer
    import vcap_pkg::*;
#(
    parameter int unsigned PPW = VCAP_PPW_DEFAULT
) (
    input  logic           clk_n_edge,
    input  logic           rst_n,
    input  logic           pix_i,
    input  logic           line_n,
    output logic [PPW-1:0] word_o,
    output logic           smp_o
);
    localparam int unsigned CNT_W = (PPW > 1) ? $clog2(PPW) : 1;
    localparam int unsigned ACC_W = (PPW > 1) ? PPW - 1 : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PPW - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [ACC_W-1:0] acc;
        logic [PPW-1:0]   word;
        logic             smp;
    } pk_state_t;

    pk_state_t s_d, s_q;
    logic [PPW-1:0] full_w;

    always_comb begin
        s_d    = s_q;
        full_w = PPW'({s_q.acc, pix_i});
        if (!line_n) begin
            s_d.cnt  = '0;
            s_d.acc  = '0;
            s_d.word = '0;
            s_d.smp  = VCAP_SMP_IDLE;
        end else begin
            s_d.acc = ACC_W'({s_q.acc, pix_i});
            if (s_q.cnt == LAST) begin
                s_d.word = full_w;
                s_d.smp  = ~s_q.smp;
                s_d.cnt  = '0;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(negedge clk_n_edge or negedge rst_n) begin
        if (!rst_n) begin
            s_q.cnt  <= '0;
            s_q.acc  <= '0;
            s_q.word <= '0;
            s_q.smp  <= VCAP_SMP_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign word_o = s_q.word;
    assign smp_o  = s_q.smp;
endmodule

// File: rtl/vcap_pair_adapter.sv
module vcap_pair_adapter
    import vcap_pkg::*;
#(
    parameter int unsigned PPW = VCAP_PPW_DEFAULT
) (
    input  logic           pix_clk,
    input  logic           rst_n,
    input  logic           ser_pix,
    input  logic           hsync_n,
    input  logic           vsync_n,
    output logic           smp_clk,
    output logic [PPW-1:0] pix_pair,
    output logic           sync_out
);
    vcap_pair_packer #(.PPW(PPW)) u_pack (
        .clk_n_edge (pix_clk),
        .rst_n      (rst_n),
        .pix_i      (ser_pix),
        .line_n     (hsync_n),
        .word_o     (pix_pair),
        .smp_o      (smp_clk)
    );

    vcap_sync_xor u_sync (
        .clk_n_edge (pix_clk),
        .rst_n      (rst_n),
        .hs_n       (hsync_n),
        .vs_n       (vsync_n),
        .sync_o     (sync_out)
    );
endmodule

// File: rtl/vcap_pair_adapter_chk.sv
module vcap_pair_adapter_chk #(
    parameter int unsigned PPW = 2
) (
    input logic           pix_clk,
    input logic           rst_n,
    input logic           hsync_n,
    input logic           vsync_n,
    input logic           smp_clk,
    input logic [PPW-1:0] pix_pair,
    input logic           sync_out
);
    // R4 / R5: a word moves only together with a sample-clock edge or a blanking clear
    p_word_with_clk_r4: assert property (@(negedge pix_clk) disable iff (!rst_n)
        (pix_pair != $past(pix_pair)) |-> ((smp_clk != $past(smp_clk)) || !$past(hsync_n)));

    // R2: no two sample-clock toggles on consecutive edges inside a line
    p_div_four_r2: assert property (@(negedge pix_clk) disable iff (!rst_n)
        (hsync_n && (smp_clk != $past(smp_clk))) |=> (!$past(hsync_n) || $stable(smp_clk)));

    // R6: merged sync follows the syncs one edge later
    p_sync_xor_r6: assert property (@(negedge pix_clk) disable iff (!rst_n)
        1'b1 |=> (sync_out == ($past(hsync_n) ^ $past(vsync_n))));

    // R7: blanking forces clock and word low
    p_blank_clear_r7: assert property (@(negedge pix_clk) disable iff (!rst_n)
        !hsync_n |=> (!smp_clk && (pix_pair == '0)));

    // R9: reset values
    always_comb begin
        if (!rst_n) begin
            p_reset_zero_r9: assert (!smp_clk && (pix_pair == '0) && !sync_out);
        end
    end
endmodule

bind vcap_pair_adapter vcap_pair_adapter_chk #(.PPW(PPW)) u_chk (
    .pix_clk  (pix_clk),
    .rst_n    (rst_n),
    .hsync_n  (hsync_n),
    .vsync_n  (vsync_n),
    .smp_clk  (smp_clk),
    .pix_pair (pix_pair),
    .sync_out (sync_out)
);

// File: tb/tb_vcap_pair_adapter.sv
`timescale 1ns/1ps
module tb_vcap_pair_adapter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_pix = 1'b0;
    logic       hsync_n = 1'b1;
    logic       vsync_n = 1'b1;
    logic       smp_clk;
    logic [1:0] pix_pair;
    logic       sync_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    vcap_pair_adapter dut (
        .pix_clk(clk), .rst_n(rst_n), .ser_pix(ser_pix),
        .hsync_n(hsync_n), .vsync_n(vsync_n),
        .smp_clk(smp_clk), .pix_pair(pix_pair), .sync_out(sync_out)
    );

    typedef struct {
        logic       smp;
        logic [1:0] word;
        logic       sync;
        string      tag;
    } exp_t;

    exp_t exp_q[$];

    // reference model state
    int         m_pos = 0;
    logic       m_left = 1'b0;
    logic [1:0] m_word = 2'b00;
    logic       m_smp = 1'b0;
    logic [7:0] lfsr = 8'h5a;

    task automatic check1(input string req, input string what, input int act, input int expv);
        checks++;
        if (act != expv) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // drive one pixel clock: inputs change on the rising edge, DUT samples on the falling edge
    task automatic drive(input logic h, input logic v, input logic p, input string tag);
        exp_t e;
        @(posedge clk);
        hsync_n = h; vsync_n = v; ser_pix = p;
        if (!h) begin
            m_pos = 0; m_smp = 1'b0; m_word = 2'b00;
        end else begin
            if (m_pos % 2 == 0) m_left = p;
            else begin
                m_word = {m_left, p};
                m_smp  = ~m_smp;
            end
            m_pos++;
        end
        e.smp = m_smp; e.word = m_word; e.sync = h ^ v; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // monitor: compare 1 ns after each falling edge
    always @(negedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check1(e.tag, "smp_clk",  int'(smp_clk),  int'(e.smp));
            check1(e.tag, "pix_pair", int'(pix_pair), int'(e.word));
            check1("R6",  "sync_out", int'(sync_out), int'(e.sync));
        end
    end

    function automatic logic next_pix();
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        return lfsr[0];
    endfunction

    task automatic line(input int npix, input int vs_at, input int vs_len);
        for (int i = 0; i < 3; i++) drive(1'b0, 1'b1, next_pix(), "R7");
        for (int i = 0; i < npix; i++) begin
            logic v;
            v = !((i >= vs_at) && (i < vs_at + vs_len));
            drive(1'b1, v, next_pix(), (i < 2) ? "R8" : "R3");
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        // R9: reset state, inputs toggling
        for (int i = 0; i < 4; i++) begin
            @(posedge clk);
            ser_pix = ~ser_pix; vsync_n = ~vsync_n;
            @(negedge clk); #1;
            check1("R9", "smp_clk",  int'(smp_clk),  0);
            check1("R9", "pix_pair", int'(pix_pair), 0);
            check1("R9", "sync_out", int'(sync_out), 0);
        end
        @(posedge clk);
        rst_n = 1'b1; vsync_n = 1'b1;
        @(negedge clk);
        // R1 R2 R3: fixed pattern, left pixel on bit 1
        for (int i = 0; i < 3; i++) drive(1'b0, 1'b1, 1'b0, "R7");
        drive(1'b1, 1'b1, 1'b1, "R8"); drive(1'b1, 1'b1, 1'b0, "R8");
        drive(1'b1, 1'b1, 1'b0, "R2"); drive(1'b1, 1'b1, 1'b1, "R2");
        drive(1'b1, 1'b1, 1'b1, "R1"); drive(1'b1, 1'b1, 1'b1, "R1");
        drive(1'b1, 1'b1, 1'b0, "R5"); // odd end: divider left mid-pair
        // R8: odd-length lines leave odd phase; next line must restart
        line(9, 100, 0);
        line(16, 3, 5);   // R6 vsync pulse inside line
        line(11, 0, 11);
        line(20, 100, 0);
        for (int i = 0; i < 2; i++) drive(1'b0, 1'b0, 1'b0, "R7");
        @(negedge clk); #2;
        check1("R4", "queue drained", exp_q.size(), 0);
        finish_run();
    end

    initial begin
        #200000;
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_run();
    end
endmodule